// File: doc/BRIEF.md
# Configurable Output Macrocell for a Sum-of-Products Logic Array

This block is one output cell of a programmable sum-of-products device. It receives four product terms from the AND array and builds the pad data, the pad tri-state enable and a feedback bit that goes back into the array. A two-bit architecture field picks one of four functions. The path can be clocked or combinatorial. The data is either the XOR of two two-term sums or a three-term sum. In the three-term form, the remaining product term acts as the output enable.

The output stage inverts. In the XOR forms the enable comes from a global active-low enable input that all cells share. In the three-term forms a polarity bit selects an active-high or active-low pad, and the register holds a pre-inverted value. This is why a freshly cleared register always shows a 1 on an enabled pad. An active-high asynchronous reset models the power-on clear of the flip-flop.

Top module: `olmc_cell`

## Requirements
- R1: The architecture field `arch` selects the function: bit 1 set means combinatorial and clear means registered, bit 0 set means three-term sum and clear means XOR of two sums (00 XOR registered, 01 registered, 10 XOR combinatorial, 11 combinatorial).
- R2: In XOR combinatorial mode `pad_out` equals NOT((pt[0] OR pt[1]) XOR (pt[2] OR pt[3])) while enabled.
- R3: In XOR registered mode the register loads (pt[0] OR pt[1]) XOR (pt[2] OR pt[3]) on each rising clock edge and `pad_out` shows its inverse.
- R4: In both three-term modes the data is S = pt[0] OR pt[1] OR pt[2]. With `pol`=0 an enabled pad shows S, and with `pol`=1 it shows NOT S. In registered mode the value appears after the next rising edge.
- R5: In both XOR modes `pad_en` equals NOT `oe_n`.
- R6: In both three-term modes `pad_en` equals pt[3], and `oe_n` has no effect.
- R7: While `pad_en` is 0, `pad_out` is 0.
- R8: Reset clears the register to 0. An enabled registered pad then reads 1 for either value of `pol`.
- R9: In registered modes `fb` is the register state: the XOR of the sums in mode 00, and S XOR NOT `pol` in mode 01. It does not depend on `pad_in` or on the enable.
- R10: In combinatorial modes `fb` is the pin value. This is the driven `pad_out` while enabled, and `pad_in` while disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Global register clock, rising edge |
| rst | input | 1 | Asynchronous active-high power-on clear |
| pt | input | 4 | Product terms from the AND array |
| oe_n | input | 1 | Global active-low output enable for XOR modes |
| arch | input | 2 | Architecture select (bit 1 combinatorial, bit 0 three-term) |
| pol | input | 1 | Output polarity for three-term modes, 1 = active low |
| pad_in | input | 1 | Value seen on the pin when the cell is not driving |
| pad_out | output | 1 | Pad data, 0 when disabled |
| pad_en | output | 1 | Pad tri-state enable |
| fb | output | 1 | Feedback bit into the AND array |

## Verification
The assertions check the enable source for each architecture on every cycle. They also check that a disabled pad reads zero, that the register state seen on feedback matches the terms captured at the previous edge, that combinatorial feedback follows the driven pin, and that the register is clear on the first cycle after reset. The directed scenarios cover things the per-cycle checks cannot show. They sweep all term patterns in each mode, check both polarities against the actual pad levels, and show that `pad_in` and `oe_n` leave a registered cell's feedback untouched. They also confirm the pad reads 1 straight out of reset.

// File: rtl/olmc_cell.sv
module olmc_cell (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] pt,
  input  logic       oe_n,
  input  logic [1:0] arch,
  input  logic       pol,
  input  logic       pad_in,
  output logic       pad_out,
  output logic       pad_en,
  output logic       fb
);

  logic is_comb, is_three;
  logic sum_lo, sum_hi, sum3;
  logic d_val, q, comb_val, drive;

  assign is_comb  = arch[1];
  assign is_three = arch[0];

  assign sum_lo = pt[0] | pt[1];
  assign sum_hi = pt[2] | pt[3];
  assign sum3   = pt[0] | pt[1] | pt[2];

  assign d_val = is_three ? (sum3 ^ ~pol) : (sum_lo ^ sum_hi);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) q <= 1'b0;
    else     q <= d_val;
  end

  assign comb_val = is_three ? (pol ? ~sum3 : sum3) : ~(sum_lo ^ sum_hi);
  assign drive    = is_comb ? comb_val : ~q;

  assign pad_en  = is_three ? pt[3] : ~oe_n;
  assign pad_out = pad_en & drive;
  assign fb      = is_comb ? (pad_en ? drive : pad_in) : q;

endmodule

// File: rtl/olmc_cell_chk.sv
module olmc_cell_chk (
  input logic       clk,
  input logic       rst,
  input logic [3:0] pt,
  input logic       oe_n,
  input logic [1:0] arch,
  input logic       pol,
  input logic       pad_out,
  input logic       pad_en,
  input logic       fb
);

  a_r5_xor_enable: assert property (@(posedge clk) disable iff (rst)
    !arch[0] |-> pad_en == !oe_n);

  a_r6_term_enable: assert property (@(posedge clk) disable iff (rst)
    arch[0] |-> pad_en == pt[3]);

  a_r7_disabled_low: assert property (@(posedge clk) disable iff (rst)
    !pad_en |-> !pad_out);

  a_r3_xor_capture: assert property (@(posedge clk) disable iff (rst)
    (!arch[1] && $past(arch) == 2'b00 && !$past(rst))
      |-> fb == ($past(pt[0] | pt[1]) ^ $past(pt[2] | pt[3])));

  a_r9_term_capture: assert property (@(posedge clk) disable iff (rst)
    (!arch[1] && $past(arch) == 2'b01 && !$past(rst))
      |-> fb == ($past(pt[0] | pt[1] | pt[2]) ^ !$past(pol)));

  a_r10_comb_feedback: assert property (@(posedge clk) disable iff (rst)
    (arch[1] && pad_en) |-> fb == pad_out);

  a_r8_clear_after_reset: assert property (@(posedge clk) disable iff (rst)
    ($fell(rst) && !arch[1]) |-> !fb);

endmodule

bind olmc_cell olmc_cell_chk u_chk (
  .clk(clk), .rst(rst), .pt(pt), .oe_n(oe_n), .arch(arch), .pol(pol),
  .pad_out(pad_out), .pad_en(pad_en), .fb(fb)
);

// File: tb/test_olmc_cell.sv
module test_olmc_cell;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] pt = 4'd0;
  logic       oe_n = 1'b0;
  logic [1:0] arch = 2'b00;
  logic       pol = 1'b0;
  logic       pad_in = 1'b0;
  logic       pad_out, pad_en, fb;

  int checks = 0;
  int fails  = 0;

  olmc_cell i_olmc_cell (
    .clk(clk), .rst(rst), .pt(pt), .oe_n(oe_n), .arch(arch), .pol(pol),
    .pad_in(pad_in), .pad_out(pad_out), .pad_en(pad_en), .fb(fb)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  function automatic logic xsum(input logic [3:0] p);
    return (p[0] | p[1]) ^ (p[2] | p[3]);
  endfunction

  function automatic logic s3(input logic [3:0] p);
    return p[0] | p[1] | p[2];
  endfunction

  task automatic drive(input logic [3:0] p);
    @(negedge clk);
    pt = p;
    #1;
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    arch = 2'b00; oe_n = 1'b0; pt = 4'hF;
    #1;
    chk("R8 reset xor pad", pad_out, 1'b1);
    chk("R8 reset fb", fb, 1'b0);
    arch = 2'b01; pt = 4'b1000;
    for (int p = 0; p < 2; p++) begin
      pol = p[0];
      #1;
      chk("R8 reset pad any polarity", pad_out, 1'b1);
    end
    @(negedge clk);
    rst = 1'b0;
    arch = 2'b00; pt = 4'h0;
    #1;
    chk("R8 pad high after release", pad_out, 1'b1);
  endtask

  task automatic t_xor_comb;
    arch = 2'b10; oe_n = 1'b0;
    for (int v = 0; v < 16; v++) begin
      drive(v[3:0]);
      chk("R2 xor comb pad", pad_out, ~xsum(v[3:0]));
      chk("R5 xor comb enable", pad_en, 1'b1);
      chk("R10 comb fb driven", fb, ~xsum(v[3:0]));
    end
  endtask

  task automatic t_comb;
    arch = 2'b11;
    for (int p = 0; p < 2; p++) begin
      pol = p[0];
      for (int v = 0; v < 8; v++) begin
        drive({1'b1, v[2:0]});
        chk("R4 comb pad", pad_out, p[0] ? ~s3({1'b0, v[2:0]}) : s3({1'b0, v[2:0]}));
        chk("R1 comb mode fb", fb, pad_out);
      end
    end
    oe_n = 1'b1;
    drive(4'b1001);
    chk("R6 oe_n ignored", pad_en, 1'b1);
    oe_n = 1'b0;
    pad_in = 1'b1;
    drive(4'b0001);
    chk("R6 term3 low disables", pad_en, 1'b0);
    chk("R7 disabled pad zero", pad_out, 1'b0);
    chk("R10 comb fb from pin", fb, 1'b1);
    pad_in = 1'b0;
    #1;
    chk("R10 comb fb follows pin", fb, 1'b0);
  endtask

  task automatic t_xor_reg;
    arch = 2'b00; oe_n = 1'b0;
    for (int v = 0; v < 16; v++) begin
      drive(v[3:0]);
      tick;
      chk("R3 xor reg pad", pad_out, ~xsum(v[3:0]));
      chk("R9 xor reg fb", fb, xsum(v[3:0]));
    end
    drive(4'b0001);
    tick;
    drive(4'b0000);
    chk("R3 holds until edge", fb, 1'b1);
    oe_n = 1'b1;
    pad_in = 1'b0;
    #1;
    chk("R5 xor enable off", pad_en, 1'b0);
    chk("R7 xor disabled pad zero", pad_out, 1'b0);
    chk("R9 fb ignores enable", fb, 1'b1);
    oe_n = 1'b0;
  endtask

  task automatic t_reg;
    arch = 2'b01;
    for (int p = 0; p < 2; p++) begin
      pol = p[0];
      for (int v = 0; v < 8; v++) begin
        drive({1'b1, v[2:0]});
        tick;
        chk("R4 reg pad", pad_out, p[0] ? ~s3({1'b0, v[2:0]}) : s3({1'b0, v[2:0]}));
        chk("R9 reg fb", fb, s3({1'b0, v[2:0]}) ^ ~p[0]);
      end
    end
    pol = 1'b0;
    drive(4'b0001);
    tick;
    pad_in = 1'b0;
    drive(4'b0000);
    chk("R6 reg term3 disables", pad_en, 1'b0);
    chk("R9 reg fb ignores pin", fb, 1'b0);
    pad_in = 1'b1;
    #1;
    chk("R9 reg fb ignores pin high", fb, 1'b0);
    chk("R1 reg mode not pin", pad_out, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset;
    t_xor_comb;
    t_comb;
    t_xor_reg;
    t_reg;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule